// File: doc/BRIEF.md
# Dual Quad-SPI Flash Connection Router

This block sits between one quad-SPI controller engine and a pair of identical serial flash devices. It routes the chip select, the serial clock and the four-lane IO bus to the devices according to a small configuration register. In single-device operation only the lower device is used. In stacked operation both devices hang off one IO bus and one clock, and a page bit picks which device's select follows the controller. In parallel operation each device has its own bus. The controller then moves a whole byte per quad clock: the even-numbered bits go to the lower device and the odd-numbered bits go to the upper device.

The controller supplies a single active-low select. The router expands it into two device selects. Device index 0 is the lower device and index 1 is the upper device. On the device side, lanes `[LANES-1:0]` form the lower bus and lanes `[2*LANES-1:LANES]` form the upper bus. In stacked operation the upper device is wired on the board to the lower bus lines and to clock 0. The mode is captured only while the controller select is high, so a transaction always completes in the mode it started in. Every output is registered, which gives one clock of latency from the controller side to the device side and back.

Top module: `qspi_dual_router`

## Requirements
- R1: After synchronous reset the state is as follows: both device selects are high, both device clocks are low, all device output enables and `ctl_din` are zero, and the configuration is zero, which means single-device mode.
- R2: On a write, configuration bit 30 enables two-device operation, bit 29 selects separate buses and bit 28 selects the upper page. All other bits have no effect. With bit 30 clear, bits 29 and 28 have no effect.
- R3: In single mode, `dev_cs_n[0]` follows `ctl_cs_n`, `dev_sck[0]` follows `ctl_sck`, the lower bus carries `ctl_dout[LANES-1:0]` and `ctl_oe[LANES-1:0]`, and `dev_cs_n[1]` stays high.
- R4: In stacked mode (bit 30 set, bit 29 clear), the select follows `ctl_cs_n` on `dev_cs_n[0]` when the page bit is 0 and on `dev_cs_n[1]` when it is 1. The other select stays high, so the two selects are never both low. The shared traffic uses the lower bus and `dev_sck[0]`.
- R5: In parallel mode (bits 30 and 29 set), both selects follow `ctl_cs_n` and both clocks follow `ctl_sck`, whatever the page bit.
- R6: In parallel mode, lower lane k carries controller bit 2k and upper lane k carries controller bit 2k+1, for both data and output enable. With LANES=4, controller byte 8'hA5 appears as 8'hC3 on `dev_io_out`.
- R7: In parallel mode, `ctl_din` bit 2k is taken from lower lane k and bit 2k+1 from upper lane k. With LANES=4, `dev_io_in` 8'hC3 returns as 8'hA5.
- R8: The mode and the page are taken from the configuration register only on clock edges at which `ctl_cs_n` is high. A configuration write while the select is low changes nothing until the select has been seen high.
- R9: Every device-side output and `ctl_din` reflect the inputs sampled at the previous clock edge, a latency of exactly one cycle.
- R10: Outside parallel mode, the upper bus output enables and data are zero, `dev_sck[1]` is low, and the upper half of `ctl_din` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | CFG_W | Configuration write word |
| ctl_cs_n | input | 1 | Controller chip select, active low |
| ctl_sck | input | 1 | Controller serial clock |
| ctl_dout | input | 2*LANES | Controller output data, low half only outside parallel mode |
| ctl_oe | input | 2*LANES | Controller per-bit output enables |
| ctl_din | output | 2*LANES | Data returned to the controller |
| dev_cs_n | output | 2 | Device selects, [0] lower, [1] upper, active low |
| dev_sck | output | 2 | Device clocks, [0] lower bus, [1] upper bus |
| dev_io_out | output | 2*LANES | Device lane outputs, low half lower bus |
| dev_io_oe | output | 2*LANES | Device lane output enables |
| dev_io_in | input | 2*LANES | Device lane inputs |

## Verification
The hardest situation to reach is a configuration write that lands while the controller select is low. It has to leave the running transaction in its old mode and take effect only after the select has been high for one edge. The stimulus reaches this case in two ways. A directed sequence starts a stacked transaction and rewrites the register in mid-transfer. The random phase also issues writes on cycles where the select is low. A bench model tracks both the written and the captured configuration, so every cycle of the random run is checked against the mode the design should be using.

// File: rtl/qdr_pkg.sv
package qdr_pkg;

  typedef enum logic [1:0] {
    ROUTE_SINGLE   = 2'd0,
    ROUTE_STACKED  = 2'd1,
    ROUTE_PARALLEL = 2'd2
  } route_mode_e;

  typedef struct packed {
    route_mode_e mode;
    logic        upper;
  } route_cfg_t;

  localparam route_cfg_t ROUTE_RESET = '{mode: ROUTE_SINGLE, upper: 1'b0};

  function automatic route_cfg_t decode_cfg(input logic two, input logic sep, input logic page);
    route_cfg_t r;
    r = ROUTE_RESET;
    if (two && sep) begin
      r.mode = ROUTE_PARALLEL;
    end else if (two) begin
      r.mode  = ROUTE_STACKED;
      r.upper = page;
    end
    return r;
  endfunction

endpackage

// File: rtl/qdr_cfg_reg.sv
module qdr_cfg_reg
  import qdr_pkg::*;
#(
  parameter int CFG_W    = 32,
  parameter int POS_TWO  = 30,
  parameter int POS_SEP  = 29,
  parameter int POS_PAGE = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             ctl_cs_n,
  output route_cfg_t       active
);

  logic two_q, sep_q, page_q;
  route_cfg_t pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      two_q  <= 1'b0;
      sep_q  <= 1'b0;
      page_q <= 1'b0;
    end else if (wr_en) begin
      two_q  <= wr_data[POS_TWO];
      sep_q  <= wr_data[POS_SEP];
      page_q <= wr_data[POS_PAGE];
    end
  end

  always_comb pending = decode_cfg(two_q, sep_q, page_q);

  // Capture only between transactions
  always_ff @(posedge clk) begin
    if (rst)           active <= ROUTE_RESET;
    else if (ctl_cs_n) active <= pending;
  end

endmodule

// File: rtl/qdr_select_gen.sv
module qdr_select_gen
  import qdr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  route_cfg_t active,
  input  logic       ctl_cs_n,
  input  logic       ctl_sck,
  output logic [1:0] dev_cs_n,
  output logic [1:0] dev_sck
);

  logic [1:0] cs_d, sck_d;

  always_comb begin
    cs_d  = 2'b11;
    sck_d = 2'b00;
    unique case (active.mode)
      ROUTE_PARALLEL: begin
        cs_d  = {2{ctl_cs_n}};
        sck_d = {2{ctl_sck}};
      end
      ROUTE_STACKED: begin
        sck_d[0] = ctl_sck;
        if (active.upper) cs_d[1] = ctl_cs_n;
        else              cs_d[0] = ctl_cs_n;
      end
      default: begin
        cs_d[0]  = ctl_cs_n;
        sck_d[0] = ctl_sck;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_cs_n <= 2'b11;
      dev_sck  <= 2'b00;
    end else begin
      dev_cs_n <= cs_d;
      dev_sck  <= sck_d;
    end
  end

endmodule

// File: rtl/qdr_lane_mux.sv
module qdr_lane_mux
  import qdr_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  route_mode_e        mode,
  input  logic [2*LANES-1:0] ctl_dout,
  input  logic [2*LANES-1:0] ctl_oe,
  input  logic [2*LANES-1:0] dev_in,
  output logic [2*LANES-1:0] dev_out,
  output logic [2*LANES-1:0] dev_oe,
  output logic [2*LANES-1:0] ctl_din
);

  localparam int BUS_W = 2 * LANES;

  logic [BUS_W-1:0] par_out, par_oe, par_din;
  logic [BUS_W-1:0] out_d, oe_d, din_d;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign par_out[k]         = ctl_dout[2*k];
    assign par_out[LANES+k]   = ctl_dout[2*k+1];
    assign par_oe[k]          = ctl_oe[2*k];
    assign par_oe[LANES+k]    = ctl_oe[2*k+1];
    assign par_din[2*k]       = dev_in[k];
    assign par_din[2*k+1]     = dev_in[LANES+k];
  end

  always_comb begin
    if (mode == ROUTE_PARALLEL) begin
      out_d = par_out;
      oe_d  = par_oe;
      din_d = par_din;
    end else begin
      out_d = {{LANES{1'b0}}, ctl_dout[LANES-1:0]};
      oe_d  = {{LANES{1'b0}}, ctl_oe[LANES-1:0]};
      din_d = {{LANES{1'b0}}, dev_in[LANES-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_out <= '0;
      dev_oe  <= '0;
      ctl_din <= '0;
    end else begin
      dev_out <= out_d;
      dev_oe  <= oe_d;
      ctl_din <= din_d;
    end
  end

endmodule

// File: rtl/qspi_dual_router.sv
module qspi_dual_router
  import qdr_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int CFG_W    = 32,
  parameter int POS_TWO  = 30,
  parameter int POS_SEP  = 29,
  parameter int POS_PAGE = 28
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr_en,
  input  logic [CFG_W-1:0]   cfg_wr_data,
  input  logic               ctl_cs_n,
  input  logic               ctl_sck,
  input  logic [2*LANES-1:0] ctl_dout,
  input  logic [2*LANES-1:0] ctl_oe,
  output logic [2*LANES-1:0] ctl_din,
  output logic [1:0]         dev_cs_n,
  output logic [1:0]         dev_sck,
  output logic [2*LANES-1:0] dev_io_out,
  output logic [2*LANES-1:0] dev_io_oe,
  input  logic [2*LANES-1:0] dev_io_in
);

  route_cfg_t active;

  qdr_cfg_reg #(
    .CFG_W(CFG_W), .POS_TWO(POS_TWO), .POS_SEP(POS_SEP), .POS_PAGE(POS_PAGE)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .ctl_cs_n(ctl_cs_n), .active(active)
  );

  qdr_select_gen u_sel (
    .clk(clk), .rst(rst), .active(active), .ctl_cs_n(ctl_cs_n),
    .ctl_sck(ctl_sck), .dev_cs_n(dev_cs_n), .dev_sck(dev_sck)
  );

  qdr_lane_mux #(.LANES(LANES)) u_mux (
    .clk(clk), .rst(rst), .mode(active.mode), .ctl_dout(ctl_dout),
    .ctl_oe(ctl_oe), .dev_in(dev_io_in), .dev_out(dev_io_out),
    .dev_oe(dev_io_oe), .ctl_din(ctl_din)
  );

endmodule

// File: rtl/qdr_checker.sv
module qdr_checker
  import qdr_pkg::*;
#(
  parameter int LANES = 4
) (
  input logic               clk,
  input logic               rst,
  input route_cfg_t         active,
  input logic               ctl_cs_n,
  input logic               ctl_sck,
  input logic [2*LANES-1:0] ctl_dout,
  input logic [1:0]         dev_cs_n,
  input logic [1:0]         dev_sck,
  input logic [2*LANES-1:0] dev_io_out,
  input logic [2*LANES-1:0] dev_io_oe,
  input logic [2*LANES-1:0] ctl_din
);

  // R1: reset drives selects high and clocks low
  p_reset_idle_r1: assert property (@(posedge clk) $past(rst) |-> (dev_cs_n == 2'b11 && dev_sck == 2'b00));

  // R4: the two selects are never low together outside parallel mode
  p_cs_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(active.mode) != ROUTE_PARALLEL) |-> (dev_cs_n != 2'b00));

  // R5: parallel selects and clocks track the controller
  p_parallel_lockstep_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(active.mode) == ROUTE_PARALLEL) |->
      (dev_cs_n == {2{$past(ctl_cs_n)}} && dev_sck == {2{$past(ctl_sck)}}));

  // R8: captured mode holds while the controller select is low
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !ctl_cs_n |=> $stable(active));

  // R10: the upper bus is quiet outside parallel mode
  p_upper_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(active.mode) != ROUTE_PARALLEL) |->
      (dev_io_oe[2*LANES-1:LANES] == '0 && dev_sck[1] == 1'b0 && ctl_din[2*LANES-1:LANES] == '0));

  for (genvar k = 0; k < LANES; k++) begin : g_chk
    // R6: lane k pair carries bits 2k and 2k+1
    p_interleave_r6: assert property (@(posedge clk) disable iff (rst)
      ($past(active.mode) == ROUTE_PARALLEL) |->
        (dev_io_out[k] == $past(ctl_dout[2*k]) && dev_io_out[LANES+k] == $past(ctl_dout[2*k+1])));
  end

endmodule

bind qspi_dual_router qdr_checker #(.LANES(LANES)) u_qdr_checker (
  .clk(clk), .rst(rst), .active(active), .ctl_cs_n(ctl_cs_n), .ctl_sck(ctl_sck),
  .ctl_dout(ctl_dout), .dev_cs_n(dev_cs_n), .dev_sck(dev_sck),
  .dev_io_out(dev_io_out), .dev_io_oe(dev_io_oe), .ctl_din(ctl_din)
);

// File: tb/qspi_dual_router_tb.sv
module qspi_dual_router_tb;

  localparam int LANES = 4;
  localparam int BW    = 2 * LANES;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_wr_en = 1'b0;
  logic [31:0]   cfg_wr_data = '0;
  logic          ctl_cs_n = 1'b1;
  logic          ctl_sck = 1'b0;
  logic [BW-1:0] ctl_dout = '0;
  logic [BW-1:0] ctl_oe = '0;
  logic [BW-1:0] ctl_din;
  logic [1:0]    dev_cs_n;
  logic [1:0]    dev_sck;
  logic [BW-1:0] dev_io_out;
  logic [BW-1:0] dev_io_oe;
  logic [BW-1:0] dev_io_in = '0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  qspi_dual_router #(.LANES(LANES)) u_dut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .ctl_cs_n(ctl_cs_n), .ctl_sck(ctl_sck), .ctl_dout(ctl_dout), .ctl_oe(ctl_oe),
    .ctl_din(ctl_din), .dev_cs_n(dev_cs_n), .dev_sck(dev_sck),
    .dev_io_out(dev_io_out), .dev_io_oe(dev_io_oe), .dev_io_in(dev_io_in)
  );

  // Model state: written config and captured mode (0 single, 1 stacked, 2 parallel)
  logic m_two = 0, m_sep = 0, m_page = 0;
  int   a_mode = 0;
  logic a_up = 0;

  logic [1:0]    e_cs, e_sck;
  logic [BW-1:0] e_out, e_oe, e_din;

  function automatic logic [BW-1:0] spread(input logic [BW-1:0] v);
    logic [BW-1:0] r;
    for (int k = 0; k < LANES; k++) begin
      r[k]       = v[2*k];
      r[LANES+k] = v[2*k+1];
    end
    return r;
  endfunction

  function automatic logic [BW-1:0] gather(input logic [BW-1:0] v);
    logic [BW-1:0] r;
    for (int k = 0; k < LANES; k++) begin
      r[2*k]   = v[k];
      r[2*k+1] = v[LANES+k];
    end
    return r;
  endfunction

  task automatic calc_exp();
    logic [BW-1:0] lowmask;
    lowmask = {{LANES{1'b0}}, {LANES{1'b1}}};
    if (a_mode == 2) begin
      e_cs = {2{ctl_cs_n}}; e_sck = {2{ctl_sck}};
      e_out = spread(ctl_dout); e_oe = spread(ctl_oe); e_din = gather(dev_io_in);
    end else begin
      e_sck = {1'b0, ctl_sck};
      if (a_mode == 1 && a_up) e_cs = {ctl_cs_n, 1'b1};
      else                     e_cs = {1'b1, ctl_cs_n};
      e_out = ctl_dout & lowmask; e_oe = ctl_oe & lowmask; e_din = dev_io_in & lowmask;
    end
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, capture at posedge, check at next negedge
  task automatic step(input logic cs_n, input logic sck, input logic [BW-1:0] d,
                      input logic [BW-1:0] oe, input logic [BW-1:0] din,
                      input logic wr, input logic [31:0] wd);
    string rsel, rio, rdin;
    ctl_cs_n = cs_n; ctl_sck = sck; ctl_dout = d; ctl_oe = oe; dev_io_in = din;
    cfg_wr_en = wr; cfg_wr_data = wd;
    calc_exp();
    rsel = (a_mode == 2) ? "R5" : (a_mode == 1) ? "R4" : "R3";
    rio  = (a_mode == 2) ? "R6" : "R10";
    rdin = (a_mode == 2) ? "R7" : "R10";
    @(posedge clk);
    if (cs_n) begin
      a_mode = (m_two && m_sep) ? 2 : m_two ? 1 : 0;
      a_up   = m_two && !m_sep && m_page;
    end
    if (wr) begin m_two = wd[30]; m_sep = wd[29]; m_page = wd[28]; end
    @(negedge clk);
    cfg_wr_en = 1'b0;
    chk({rsel, " R8 select"}, 64'(dev_cs_n), 64'(e_cs));
    chk({rsel, " R9 clock"}, 64'(dev_sck), 64'(e_sck));
    chk({rio, " io out"}, 64'(dev_io_out), 64'(e_out));
    chk({rio, " io oe"}, 64'(dev_io_oe), 64'(e_oe));
    chk({rdin, " read"}, 64'(ctl_din), 64'(e_din));
  endtask

  task automatic wcfg(input logic [31:0] wd);
    step(1'b1, 1'b0, '0, '0, '0, 1'b1, wd);
    step(1'b1, 1'b0, '0, '0, '0, 1'b0, '0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int seed;
    logic [31:0] r;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 cs", 64'(dev_cs_n), 64'h3);
    chk("R1 sck", 64'(dev_sck), 64'h0);
    chk("R1 oe", 64'(dev_io_oe), 64'h0);
    chk("R1 din", 64'(ctl_din), 64'h0);
    // R1/R3: single mode by default
    step(1'b0, 1'b1, 8'hA5, 8'h0F, 8'h3C, 1'b0, '0);
    step(1'b0, 1'b0, 8'h5A, 8'hFF, 8'hF6, 1'b0, '0);
    chk("R3 upper select idle", 64'(dev_cs_n[1]), 64'h1);
    step(1'b1, 1'b0, '0, '0, '0, 1'b0, '0);
    // R2: non-mode bits ignored, and bits 29/28 ignored without bit 30
    wcfg(32'h8FFF_FFFF);
    wcfg(32'h3000_0000);
    step(1'b0, 1'b1, 8'hFF, 8'hFF, 8'hFF, 1'b0, '0);
    chk("R2 still single", 64'(dev_cs_n), 64'h2);
    step(1'b1, 1'b0, '0, '0, '0, 1'b0, '0);
    // R4: stacked page 0 then page 1
    wcfg(32'h4000_0000);
    step(1'b0, 1'b1, 8'h96, 8'h0F, 8'h21, 1'b0, '0);
    chk("R4 lower page", 64'(dev_cs_n), 64'h2);
    step(1'b1, 1'b0, '0, '0, '0, 1'b0, '0);
    wcfg(32'h5000_0000);
    step(1'b0, 1'b1, 8'h69, 8'h0F, 8'h12, 1'b0, '0);
    chk("R4 upper page", 64'(dev_cs_n), 64'h1);
    // R8: mid-transaction write to parallel mode has no effect yet
    step(1'b0, 1'b0, 8'hA5, 8'hFF, 8'hC3, 1'b1, 32'h6000_0000);
    step(1'b0, 1'b1, 8'hA5, 8'hFF, 8'hC3, 1'b0, '0);
    chk("R8 mode held during transfer", 64'(dev_cs_n), 64'h1);
    step(1'b1, 1'b0, '0, '0, '0, 1'b0, '0);
    // R5/R6/R7: parallel with known pattern
    step(1'b0, 1'b1, 8'hA5, 8'hFF, 8'hC3, 1'b0, '0);
    chk("R6 A5 interleave", 64'(dev_io_out), 64'hC3);
    chk("R7 C3 deinterleave", 64'(ctl_din), 64'hA5);
    chk("R5 both selects", 64'(dev_cs_n), 64'h0);
    step(1'b1, 1'b0, '0, '0, '0, 1'b0, '0);
    // Random phase, writes allowed with select low (R8)
    for (int i = 0; i < 3000; i++) begin
      r = $urandom;
      step(r[0] & r[1], r[2], 8'($urandom), 8'($urandom), 8'($urandom),
           (r[7:4] == 4'h0), {r[31], r[30:28], 28'($urandom)});
    end
    step(1'b1, 1'b0, '0, '0, '0, 1'b0, '0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule